// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is a byte-wide latched output port that hands data to a slow peripheral, such as a printer, through a two-wire handshake. The host writes a byte over a small register bus with chip select, read strobe, write strobe and a two-bit address. The byte is latched onto the peripheral data pins and stays there. When the write strobe ends, an active-low "buffer full" line tells the peripheral that a byte is waiting. The peripheral pulls its active-low acknowledge line to take the byte, and this releases the buffer-full line. Once the acknowledge has returned high, the port raises an interrupt request so that the host can send the next byte. A control bit enables or masks that interrupt.

A single-bit set/reset control word sets the interrupt enable and, for the first port variant, two spare general-purpose output bits. The host can read back the latched byte and a status image. The parameter `PORT_A` picks the variant. With `PORT_A` = 1, the enable sits at bit position 6 and positions 5 and 4 are free for general use. With `PORT_A` = 0, the enable sits at position 2, the status bits are packed low, and no spare outputs exist. All inputs are sampled on the rising clock edge.

Top module: `strobe_out_port`

## Requirements
- R1: While `rst` is high at a clock edge, the port clears its state. After that edge, `pdata` is 0, `obf_n` is 1, `intr` is 0, `gp` is 0 and the interrupt enable is 0.
- R2: A data write is an edge where `cs_n`=0, `wr_n`=0 and `addr`=0. At that edge, `pdata` takes `wdata`. At no other edge does `pdata` change: reads, control writes, acknowledges and writes with `cs_n`=1 leave it unchanged.
- R3: `obf_n` goes low after the first edge at which `wr_n` is sampled high following a data write. It never falls without such a write.
- R4: When `ack_n` is sampled low while `obf_n` is low, `obf_n` returns high after that edge.
- R5: An acknowledge sampled while `obf_n` is high has no effect. `obf_n`, `intr` and `pdata` keep their values.
- R6: After an acknowledge has cleared `obf_n`, `intr` rises at the first later edge where `ack_n` is sampled high, provided the enable is 1. `intr` is never high while `obf_n` is low.
- R7: `intr` drops at the edge where the next data write is first sampled. This happens while the strobe is still low, before `obf_n` falls.
- R8: A control write is an edge where `cs_n`=0, `wr_n`=0, `addr`=3 and `wdata[7]`=0. It loads `wdata[0]` into the bit selected by `wdata[3:1]`. Position 6 (or 2 when `PORT_A`=0) is the interrupt enable. Clearing the enable masks a pending `intr`, and setting it again restores `intr`.
- R9: With `PORT_A`=1, positions 5 and 4 drive `gp[1]` and `gp[0]`. Other positions have no effect. A control word with `wdata[7]`=1 is ignored completely.
- R10: With `cs_n`=0 and `rd_n`=0, `rdata` returns values by address. Address 0 gives the latched byte. Address 2 gives the status image {`obf_n`, enable, `gp[1]`, `gp[0]`, `intr`, 3'b000} from bit 7 down to bit 0. With `PORT_A`=0, the image is {5'b0, enable, `obf_n`, `intr`}. In every other case `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select: 0 data, 2 status, 3 control |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data, 0 when not reading |
| pdata | output | DW | Latched byte toward the peripheral |
| obf_n | output | 1 | Active-low buffer-full indication |
| ack_n | input | 1 | Active-low acknowledge from the peripheral |
| intr | output | 1 | Interrupt request for the next byte |
| gp | output | 2 | General-purpose control outputs (0 when `PORT_A`=0) |

## Verification
The assertions take for granted that the host holds `cs_n`, `addr` and `wdata` steady for the whole time `wr_n` is low, so one strobe belongs to one register. They also assume that the peripheral pulls `ack_n` only as an answer to a full buffer, or as a deliberately stray pulse. The bench drives every bus cycle as one low cycle followed by a release, and it applies each acknowledge as a single low cycle after the buffer-full line has fallen. The one exception is the directed test of stray acknowledges. Overlap between a write strobe and an acknowledge is never generated.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_NONE = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic data_wr;
        logic ctrl_wr;
        logic data_rd;
        logic stat_rd;
    } bus_req_t;

    typedef struct packed {
        logic       obf_n;
        logic       intr;
        logic       inte;
        logic [1:0] gp;
    } port_state_t;

    localparam int STAT_W = 8;

    function automatic logic [2:0] inte_pos(input bit port_a);
        return port_a ? 3'd6 : 3'd2;
    endfunction

    function automatic logic [STAT_W-1:0] status_image(input bit port_a,
                                                       input port_state_t s);
        if (port_a)
            return {s.obf_n, s.inte, s.gp, s.intr, 3'b000};
        else
            return {5'b00000, s.inte, s.obf_n, s.intr};
    endfunction

endpackage

// File: rtl/sop_bus_decode.sv
module sop_bus_decode
    import sop_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [1:0]          addr,
    input  logic                ctrl_msb,
    input  logic [DW-1:0]       latched,
    input  logic [STAT_W-1:0]   status,
    output bus_req_t            req,
    output logic [DW-1:0]       rdata
);
    reg_sel_e sel;

    always_comb begin
        sel         = reg_sel_e'(addr);
        req         = '0;
        req.data_wr = !cs_n && !wr_n && (sel == REG_DATA);
        req.ctrl_wr = !cs_n && !wr_n && (sel == REG_CTRL) && !ctrl_msb;
        req.data_rd = !cs_n && !rd_n && (sel == REG_DATA);
        req.stat_rd = !cs_n && !rd_n && (sel == REG_STAT);
    end

    always_comb begin
        rdata = '0;
        if (req.data_rd)
            rdata = latched;
        else if (req.stat_rd)
            rdata[STAT_W-1:0] = status;
    end

endmodule

// File: rtl/sop_ctrl_bits.sv
module sop_ctrl_bits
    import sop_pkg::*;
#(
    parameter bit PORT_A = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [2:0] bit_sel,
    input  logic       bit_val,
    output logic       inte,
    output logic [1:0] gp
);
    localparam logic [2:0] INTE_POS = inte_pos(PORT_A);

    always_ff @(posedge clk) begin
        if (rst)
            inte <= 1'b0;
        else if (ctrl_wr && bit_sel == INTE_POS)
            inte <= bit_val;
    end

    generate
        if (PORT_A) begin : g_spare
            logic [1:0] gp_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    gp_q <= 2'b00;
                end else if (ctrl_wr) begin
                    if (bit_sel == 3'd5) gp_q[1] <= bit_val;
                    if (bit_sel == 3'd4) gp_q[0] <= bit_val;
                end
            end
            assign gp = gp_q;
        end else begin : g_nospare
            assign gp = 2'b00;
        end
    endgenerate

endmodule

// File: rtl/sop_out_engine.sv
module sop_out_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    input  logic          ack_n,
    input  logic          inte,
    output logic [DW-1:0] pdata,
    output logic          obf_n,
    output logic          intr
);
    logic [DW-1:0] data_q;
    logic          wr_q;
    logic          obf_n_q;
    logic          ack_pend_q;
    logic          ready_q;
    logic          wr_end;
    logic          ack_take;

    assign wr_end   = wr_q && !data_wr;
    assign ack_take = !ack_n && !obf_n_q && !wr_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= '0;
            wr_q       <= 1'b0;
            obf_n_q    <= 1'b1;
            ack_pend_q <= 1'b0;
            ready_q    <= 1'b0;
        end else begin
            wr_q <= data_wr;
            if (data_wr)
                data_q <= wdata;

            if (wr_end)
                obf_n_q <= 1'b0;
            else if (ack_take)
                obf_n_q <= 1'b1;

            if (data_wr)
                ack_pend_q <= 1'b0;
            else if (ack_take)
                ack_pend_q <= 1'b1;
            else if (ack_n && ack_pend_q)
                ack_pend_q <= 1'b0;

            if (data_wr)
                ready_q <= 1'b0;
            else if (ack_n && ack_pend_q)
                ready_q <= 1'b1;
        end
    end

    assign pdata = data_q;
    assign obf_n = obf_n_q;
    assign intr  = ready_q && inte;

endmodule

// File: rtl/strobe_out_port.sv
module strobe_out_port
    import sop_pkg::*;
#(
    parameter int DW     = 8,
    parameter bit PORT_A = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] pdata,
    output logic          obf_n,
    input  logic          ack_n,
    output logic          intr,
    output logic [1:0]    gp
);
    bus_req_t          req;
    port_state_t       st;
    logic              inte;
    logic [STAT_W-1:0] status;

    sop_bus_decode #(.DW(DW)) u_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .ctrl_msb (wdata[7]),
        .latched  (pdata),
        .status   (status),
        .req      (req),
        .rdata    (rdata)
    );

    sop_ctrl_bits #(.PORT_A(PORT_A)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (req.ctrl_wr),
        .bit_sel (wdata[3:1]),
        .bit_val (wdata[0]),
        .inte    (inte),
        .gp      (gp)
    );

    sop_out_engine #(.DW(DW)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .data_wr (req.data_wr),
        .wdata   (wdata),
        .ack_n   (ack_n),
        .inte    (inte),
        .pdata   (pdata),
        .obf_n   (obf_n),
        .intr    (intr)
    );

    always_comb begin
        st.obf_n = obf_n;
        st.intr  = intr;
        st.inte  = inte;
        st.gp    = gp;
        status   = status_image(PORT_A, st);
    end

endmodule

// File: rtl/strobe_out_port_chk.sv
module strobe_out_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          wr_n,
    input logic [1:0]    addr,
    input logic [DW-1:0] pdata,
    input logic          obf_n,
    input logic          ack_n,
    input logic          intr,
    input logic          inte
);
    // R2
    pdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || wr_n || addr != 2'd0) |=> $stable(pdata));

    // R3
    obf_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (obf_n && wr_n && $past(wr_n)) |=> obf_n);

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !obf_n && wr_n) |=> obf_n);

    // R6
    intr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        intr |-> (obf_n && inte));

    // R7
    intr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && addr == 2'd0) |=> !intr);

    // R1
    always @(posedge clk) begin
        if ($past(rst)) begin
            rst_state_chk: assert (obf_n && !intr && pdata == '0);
        end
    end
endmodule

bind strobe_out_port strobe_out_port_chk #(.DW(DW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .wr_n  (wr_n),
    .addr  (addr),
    .pdata (pdata),
    .obf_n (obf_n),
    .ack_n (ack_n),
    .intr  (intr),
    .inte  (inte)
);

// File: tb/sim_strobe_out_port.sv
module sim_strobe_out_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ack_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, pdata;
    logic       obf_n, intr;
    logic [1:0] gp;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // byte in [7:0], interrupt enable for that transfer in [8]
    localparam logic [8:0] VEC [6] = '{
        9'h1A5, 9'h03C, 9'h1FF, 9'h100, 9'h081, 9'h15A
    };

    always #10 clk = ~clk;

    strobe_out_port u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pdata(pdata),
        .obf_n(obf_n), .ack_n(ack_n), .intr(intr), .gp(gp)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic csn);
        @(negedge clk);
        cs_n = csn; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic rdn, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = rdn; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        ack_n = 1'b0;
        @(negedge clk);
        ack_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 obf_n", {7'd0, obf_n}, 8'h01);
        check("R1 intr", {7'd0, intr}, 8'h00);
        check("R1 pdata", pdata, 8'h00);
        bus_read(2'd2, 1'b0, rd);
        check("R1 R10 status", rd, 8'h80);

        foreach (VEC[i]) begin
            // R8 enable at position 6
            bus_write(2'd3, {4'h0, 3'd6, VEC[i][8]}, 1'b0);
            bus_write(2'd0, VEC[i][7:0], 1'b0);
            check("R7 intr drop", {7'd0, intr}, 8'h00);
            check("R2 pdata", pdata, VEC[i][7:0]);
            check("R3 obf before end", {7'd0, obf_n}, 8'h01);
            @(negedge clk);
            check("R3 obf low", {7'd0, obf_n}, 8'h00);
            ack_pulse();
            check("R4 obf release", {7'd0, obf_n}, 8'h01);
            check("R6 intr wait", {7'd0, intr}, 8'h00);
            @(negedge clk);
            check("R6 intr", {7'd0, intr}, {7'd0, VEC[i][8]});
            check("R2 pdata held", pdata, VEC[i][7:0]);
        end

        // R5 stray acknowledge
        ack_pulse();
        @(negedge clk);
        check("R5 obf", {7'd0, obf_n}, 8'h01);
        check("R5 intr", {7'd0, intr}, 8'h01);
        check("R5 pdata", pdata, 8'h5A);

        // R8 mask and unmask
        bus_write(2'd3, 8'h0C, 1'b0);
        check("R8 masked", {7'd0, intr}, 8'h00);
        bus_write(2'd3, 8'h0D, 1'b0);
        check("R8 unmasked", {7'd0, intr}, 8'h01);

        // R9 spare bits
        bus_write(2'd3, 8'h0B, 1'b0);
        check("R9 gp bit5", {6'd0, gp}, 8'h02);
        bus_write(2'd3, 8'h09, 1'b0);
        check("R9 gp bit4", {6'd0, gp}, 8'h03);
        bus_write(2'd3, 8'h0A, 1'b0);
        check("R9 gp clr5", {6'd0, gp}, 8'h01);
        bus_write(2'd3, 8'h01, 1'b0);
        check("R9 other pos", {6'd0, gp}, 8'h01);
        bus_write(2'd3, 8'h8C, 1'b0);
        check("R9 mode word", {7'd0, intr}, 8'h01);
        check("R2 ctrl no data", pdata, 8'h5A);

        // R10 reads
        bus_read(2'd2, 1'b0, rd);
        check("R10 status", rd, 8'hD8);
        bus_read(2'd0, 1'b0, rd);
        check("R10 data", rd, 8'h5A);
        bus_read(2'd0, 1'b1, rd);
        check("R10 idle", rd, 8'h00);

        // R2 deselected write
        bus_write(2'd0, 8'h33, 1'b1);
        @(negedge clk);
        check("R2 cs_n high", pdata, 8'h5A);
        check("R3 no write", {7'd0, obf_n}, 8'h01);
        check("R7 no write", {7'd0, intr}, 8'h01);

        // R1 reset mid-run
        bus_write(2'd0, 8'hC3, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pdata", pdata, 8'h00);
        check("R1 obf_n", {7'd0, obf_n}, 8'h01);
        check("R1 gp", {6'd0, gp}, 8'h00);
        bus_read(2'd2, 1'b0, rd);
        check("R1 status", rd, 8'h80);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule